// File: doc/BRIEF.md
# Byte-Swapping Configuration and Port-I/O Access Adapter

This adapter joins a big-endian processor-side request channel to a little-endian downstream target that performs PCI configuration cycles and I/O-port cycles. Each processor request names one of two windows: a 16 MB configuration window or a 64 KB I/O-port window. It also carries an offset, a transfer size of one, two or four bytes, a direction and write data. The adapter builds the downstream address from the window and the offset. It reorders the data lanes according to the size, both on the way out and on the way back.

For configuration requests, the downstream address keeps the 24 offset bits and sets bit 31, the configuration-enable flag. For I/O-port requests, only the port bits are kept. Halfword data has its two low bytes exchanged and word data has all four bytes reversed. Byte data is left alone. Writes are posted. A read stays outstanding until the target returns a response pulse. Only one read may be outstanding at a time, but the request that follows can be accepted in the same cycle that the pending response arrives.

Top module: `cfg_swap_bridge`

## Requirements
- R1: A configuration request (up_space = 0) presents dn_addr with bits [23:0] equal to up_addr, bit 31 set to 1 and bits [30:24] cleared.
- R2: An I/O-port request (up_space = 1) presents dn_addr with bits [15:0] equal to up_addr[15:0] and every bit above 15 cleared, whatever the upper offset bits hold.
- R3: For size code 0 (byte), write data reaches dn_wdata unchanged and read data reaches up_rsp_rdata unchanged.
- R4: For size code 1 (halfword), data in either direction becomes {16'h0, d[7:0], d[15:8]}.
- R5: For size codes 2 (word) and 3 (treated as word), data in either direction becomes {d[7:0], d[15:8], d[23:16], d[31:24]}.
- R6: With no read outstanding, dn_valid follows up_valid and up_ready follows dn_ready. A request held under back-pressure stays visible downstream until it is accepted. dn_write and dn_size copy the request.
- R7: After a read is accepted, up_ready and dn_valid stay low until dn_rsp_valid arrives.
- R8: up_rsp_valid follows dn_rsp_valid in the same cycle. The response is reordered by the size of the read it answers, even when a new read of another size is accepted in that same cycle.
- R9: After reset, and after an accepted write, no read is outstanding, so up_ready equals dn_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_valid | input | 1 | Processor request valid |
| up_ready | output | 1 | Request accepted when high with up_valid |
| up_space | input | 1 | Window: 0 configuration, 1 I/O port |
| up_write | input | 1 | 1 write, 0 read |
| up_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| up_addr | input | 24 | Offset inside the window |
| up_wdata | input | 32 | Big-endian write data |
| up_rsp_valid | output | 1 | Read response pulse to processor |
| up_rsp_rdata | output | 32 | Reordered read data |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream target accepts |
| dn_space | output | 1 | Window of the forwarded request |
| dn_write | output | 1 | Direction of the forwarded request |
| dn_size | output | 2 | Size of the forwarded request |
| dn_addr | output | 32 | Formed downstream address |
| dn_wdata | output | 32 | Little-endian write data |
| dn_rsp_valid | input | 1 | Target read response pulse |
| dn_rsp_rdata | input | 32 | Little-endian read data |

## Verification
The interesting overlap is a returning read response in the same cycle that the next request is accepted. Here the held size must still reorder the old data while the size register takes the new request's value. The bench provokes this by driving dn_rsp_valid for a halfword read while it presents a word read. It checks that the response is halfword-swapped, that up_ready is high in that cycle, and that the later response for the word read is fully reversed. Random sequences with back-pressure and random response delays repeat the overlap with mixed sizes.

// File: rtl/cfg_swap_bridge.sv
module cfg_swap_bridge #(
  parameter int CFG_AW = 24,
  parameter int IO_AW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic              up_space,
  input  logic              up_write,
  input  logic [1:0]        up_size,
  input  logic [CFG_AW-1:0] up_addr,
  input  logic [31:0]       up_wdata,
  output logic              up_rsp_valid,
  output logic [31:0]       up_rsp_rdata,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_space,
  output logic              dn_write,
  output logic [1:0]        dn_size,
  output logic [31:0]       dn_addr,
  output logic [31:0]       dn_wdata,
  input  logic              dn_rsp_valid,
  input  logic [31:0]       dn_rsp_rdata
);

  localparam int CFG_PAD = 31 - CFG_AW;
  localparam int IO_PAD  = 32 - IO_AW;

  function automatic logic [31:0] lane_swap(input logic [31:0] d, input logic [1:0] sz);
    case (sz)
      2'd0:    return d;
      2'd1:    return {16'h0000, d[7:0], d[15:8]};
      default: return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
  endfunction

  logic       rd_pend;
  logic [1:0] rd_size;
  logic       gate_open;
  logic       accept;

  assign gate_open = !rd_pend || dn_rsp_valid;
  assign dn_valid  = up_valid && gate_open;
  assign up_ready  = dn_ready && gate_open;
  assign accept    = up_valid && up_ready;

  assign dn_space = up_space;
  assign dn_write = up_write;
  assign dn_size  = up_size;
  assign dn_wdata = lane_swap(up_wdata, up_size);
  assign dn_addr  = up_space ? {{IO_PAD{1'b0}}, up_addr[IO_AW-1:0]}
                             : {1'b1, {CFG_PAD{1'b0}}, up_addr};

  assign up_rsp_valid = dn_rsp_valid;
  assign up_rsp_rdata = lane_swap(dn_rsp_rdata, rd_size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      rd_size <= 2'd0;
    end else if (accept && !up_write) begin
      rd_pend <= 1'b1;
      rd_size <= up_size;
    end else if (dn_rsp_valid) begin
      rd_pend <= 1'b0;
    end
  end

  assert_cfg_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_space |-> dn_addr[31] && dn_addr[CFG_AW-1:0] == up_addr);

  assert_io_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_space |-> dn_addr[31:IO_AW] == '0);

  assert_byte_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_write && dn_size == 2'd0 |-> dn_wdata == up_wdata);

  assert_word_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_size[1] |-> $countones(dn_wdata) == $countones(up_wdata));

  assert_one_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !up_write && !dn_rsp_valid |=> !up_ready || dn_rsp_valid);

  assert_rsp_expected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dn_rsp_valid |-> rd_pend);

  assert_write_posted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && up_write && !rd_pend |=> !rd_pend);

endmodule

// File: tb/test_cfg_swap_bridge.sv
`timescale 1ns/1ps
module test_cfg_swap_bridge;
  logic clk = 0, rst_n = 0;
  logic up_valid = 0, up_space = 0, up_write = 0;
  logic [1:0] up_size = 0;
  logic [23:0] up_addr = 0;
  logic [31:0] up_wdata = 0, dn_rsp_rdata = 0;
  logic dn_ready = 0, dn_rsp_valid = 0;
  logic up_ready, up_rsp_valid, dn_valid, dn_space, dn_write;
  logic [1:0] dn_size;
  logic [31:0] up_rsp_rdata, dn_addr, dn_wdata;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  cfg_swap_bridge i_cfg_swap_bridge (.*);

  function automatic logic [31:0] exp_addr(input logic sp, input logic [23:0] a);
    logic [31:0] r = 32'h0;
    if (sp) r[15:0] = a[15:0];
    else begin r[23:0] = a; r[31] = 1'b1; end
    return r;
  endfunction

  function automatic logic [31:0] exp_data(input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] r = 32'h0;
    if (sz == 2'd0) r = d;
    else if (sz == 2'd1) begin r[15:8] = d[7:0]; r[7:0] = d[15:8]; end
    else for (int k = 0; k < 4; k++) r[8*k +: 8] = d[8*(3-k) +: 8];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string size_tag(input logic [1:0] sz);
    return sz == 2'd0 ? "R3" : (sz == 2'd1 ? "R4" : "R5");
  endfunction

  // one request with optional stall cycles and response delay
  task automatic run_op(input logic sp, input logic wr, input logic [1:0] sz,
                        input logic [23:0] a, input logic [31:0] wd,
                        input logic [31:0] rd, input int stall, input int delay);
    @(negedge clk);
    up_valid = 1; up_space = sp; up_write = wr; up_size = sz; up_addr = a; up_wdata = wd;
    dn_ready = 0;
    for (int s = 0; s < stall; s++) begin
      #1;
      chk("R6 stall ready", {31'h0, up_ready}, 32'h0);
      chk("R6 stall valid", {31'h0, dn_valid}, 32'h1);
      @(negedge clk);
    end
    dn_ready = 1;
    #1;
    chk(sp ? "R2 addr" : "R1 addr", dn_addr, exp_addr(sp, a));
    chk("R6 ready", {31'h0, up_ready}, 32'h1);
    chk("R6 fields", {29'h0, dn_write, dn_size}, {29'h0, wr, sz});
    if (wr) chk({size_tag(sz), " wdata"}, dn_wdata, exp_data(sz, wd));
    @(negedge clk);
    up_valid = 0;
    if (wr) begin
      #1; chk("R9 posted", {31'h0, up_ready}, 32'h1);
    end else begin
      for (int s = 0; s < delay; s++) begin
        up_valid = 1; #1;
        chk("R7 blocked", {30'h0, up_ready, dn_valid}, 32'h0);
        up_valid = 0;
        @(negedge clk);
      end
      dn_rsp_valid = 1; dn_rsp_rdata = rd; #1;
      chk("R8 rsp valid", {31'h0, up_rsp_valid}, 32'h1);
      chk({size_tag(sz), " rdata"}, up_rsp_rdata, exp_data(sz, rd));
      @(negedge clk);
      dn_rsp_valid = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    dn_ready = 1;
    #1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R9 reset ready", {31'h0, up_ready}, 32'h1);
    chk("R9 reset valid", {31'h0, dn_valid}, 32'h0);
    chk("R8 reset rsp", {31'h0, up_rsp_valid}, 32'h0);

    run_op(0, 1, 2'd2, 24'hFFFFFF, 32'h11223344, 0, 0, 0);
    run_op(1, 1, 2'd1, 24'hAB1234, 32'hDEADBEEF, 0, 2, 0);
    run_op(0, 0, 2'd0, 24'h000000, 0, 32'hCAFEF00D, 0, 1);
    run_op(1, 0, 2'd3, 24'hFF0001, 0, 32'h01020304, 1, 3);
    run_op(0, 1, 2'd0, 24'h800000, 32'hA5A5005A, 0, 0, 0);

    // overlap: halfword response returns while a word read is accepted (R8)
    @(negedge clk);
    up_valid = 1; up_space = 0; up_write = 0; up_size = 2'd1; up_addr = 24'h000010;
    dn_ready = 1;
    @(negedge clk);
    up_size = 2'd2; up_addr = 24'h000014;
    dn_rsp_valid = 1; dn_rsp_rdata = 32'h0000BEEF; #1;
    chk("R8 overlap ready", {31'h0, up_ready}, 32'h1);
    chk("R8 overlap old size", up_rsp_rdata, 32'h0000EFBE);
    @(negedge clk);
    up_valid = 0; dn_rsp_valid = 1; dn_rsp_rdata = 32'h12345678; #1;
    chk("R8 overlap new size", up_rsp_rdata, 32'h78563412);
    @(negedge clk);
    dn_rsp_valid = 0;

    for (int n = 0; n < 400; n++) begin
      logic [31:0] r0, r1, r2;
      r0 = $urandom(n + 7); r1 = $urandom; r2 = $urandom;
      run_op(r0[0], r0[1], r0[3:2], r1[23:0], r2, ~r2 ^ r1, int'(r0[5:4]), int'(r0[7:6]));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule